// File: doc/BRIEF.md
# Cascadable Column Data Loader

This block captures one display line of pixel codes for a column driver. Each load-clock edge accepts one input word that carries six pixel codes and writes them into the next group of six channel registers. A single chip holds a parameterised number of channels (480 by default, so 80 groups per line). Filling only happens after the block is armed by a start pulse. When the last group has been written, the block parks itself and ignores the clock until it is armed again. A rising edge on the line-latch strobe also returns it to the parked state with the fill pointer cleared.

Several loaders can be chained across a wide panel. Each device has two bidirectional start-pulse pins, and a direction input selects which of them listens and which one drives the next device. The same input sets the fill order: channels from lowest to highest, or from highest to lowest. The start-pulse output is timed so that the next device takes its first group on the clock right after this device's last group. Two inversion controls can complement the lower three or the upper three pixel codes of the word as it arrives.

The controller has two states, STANDBY and LOADING, and five named transitions:
- ARM: STANDBY to LOADING when the start pulse is seen.
- ADVANCE: LOADING to LOADING when a group is written and the pointer steps on.
- FINISH: LOADING to STANDBY when the last group is written.
- ABORT: LOADING to STANDBY when the latch strobe rises.
- RESTART: LOADING to LOADING when a start pulse arrives during filling; the pointer goes back to 0.

Top module: `col_loader`

## Requirements
- R1: The input word holds six codes of 6 bits each; code p sits in `pix_in[6p+5:6p]`, and bit 0 of each code is its least significant bit. The code reaches the channel register with its bits unchanged, for all 64 values.
- R2: A start pulse that is high at a rising clock edge arms the loader. That edge writes no channel. The first group is written at the next rising edge.
- R3: After the last group is written, the block is in STANDBY. Further clock edges change no channel until a new start pulse arrives.
- R4: With `dir_up` high, `sp_a` is the start input and `sp_b` is the start output. Group g, pixel p (both counted from 0) goes to channel 6g+p.
- R5: With `dir_up` low, `sp_b` is the start input and `sp_a` is the start output. Group g, pixel p goes to channel 6(G-1-g)+p, where G is the group count. The first group therefore puts pixels 3..5 on the top three channels.
- R6: With `inv_lo` high, codes 0..2 are stored bitwise complemented. With `inv_hi` high, codes 3..5 are stored complemented. With both low, data passes unchanged.
- R7: A rising edge of `line_strobe` moves the block to STANDBY with the pointer at 0, and nothing is written at that edge. A strobe held high does not trigger again.
- R8: If a start pulse and a strobe rising edge fall on the same clock edge, the start pulse wins and the block is armed.
- R9: The start output is high for exactly the one clock period before the edge that writes the last group, and low at all other times. Channel data is exposed as `chan_data[6c+5:6c]` for channel c.
- R10: When synchronous reset is high at a clock edge, the block enters STANDBY, the pointer is 0, the start output is low and all channel registers are 0.
- R11: A start pulse that arrives during LOADING restarts filling at group 0. Nothing is written at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Load clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dir_up | input | 1 | Fill direction and start-pin role select |
| line_strobe | input | 1 | Line-latch strobe; its rising edge clears the pointer |
| inv_lo | input | 1 | Complements pixel codes 0..2 |
| inv_hi | input | 1 | Complements pixel codes 3..5 |
| pix_in | input | PIX_PER_GRP*PIX_W | Six pixel codes per load clock |
| sp_a | inout | 1 | Start pin A: input when `dir_up` is high, output when low |
| sp_b | inout | 1 | Start pin B: output when `dir_up` is high, input when low |
| chan_data | output | CHANNELS*PIX_W | All channel registers, flattened |

## Verification
Some events share a clock edge, and the test judges the winner by the channel contents and the pointer position that follow:
- A start pulse on the same edge as a strobe rising edge.
- A strobe rising edge on an edge where a group write was due.
- A fresh start pulse in the middle of filling.

The bench provokes each of these collisions on purpose. It then fills a full line and compares every channel against an arithmetic model of the fill. This shows whether the colliding edge wrote anything and whether filling began again from group 0. The cascade pulse timing is checked on every cycle of every sweep over direction and inversion settings, so a pulse that lands on the same edge as the final write is also caught.

// File: rtl/col_loader_pkg.sv
`timescale 1ns/1ps
package col_loader_pkg;
    typedef enum logic [0:0] {
        ST_STANDBY = 1'b0,
        ST_LOADING = 1'b1
    } fill_state_e;
endpackage

// File: rtl/col_fill_ctrl.sv
`timescale 1ns/1ps
module col_fill_ctrl
    import col_loader_pkg::*;
#(
    parameter int GROUPS = 80,
    localparam int PTR_W = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_in,
    input  logic             strobe,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_ptr,
    output logic             sp_out
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(GROUPS - 1);

    fill_state_e      state_q, state_d;
    logic [PTR_W-1:0] ptr_q, ptr_d;
    logic             strb_q;
    logic             strb_rise;

    assign strb_rise = strobe & ~strb_q;

    // next-state: ARM, ADVANCE, FINISH, ABORT, RESTART
    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        unique case (state_q)
            ST_STANDBY: begin
                ptr_d = '0;
                if (start_in) begin
                    state_d = ST_LOADING;          // ARM
                end
            end
            ST_LOADING: begin
                if (start_in) begin
                    ptr_d = '0;                    // RESTART
                end else if (strb_rise) begin
                    state_d = ST_STANDBY;          // ABORT
                    ptr_d   = '0;
                end else if (ptr_q == LAST) begin
                    state_d = ST_STANDBY;          // FINISH
                    ptr_d   = '0;
                end else begin
                    ptr_d = ptr_q + 1'b1;          // ADVANCE
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_STANDBY;
            ptr_q   <= '0;
            strb_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
            strb_q  <= strobe;
        end
    end

    // outputs
    always_comb begin
        wr_en  = (state_q == ST_LOADING) && !start_in && !strb_rise;
        wr_ptr = ptr_q;
        sp_out = (state_q == ST_LOADING) && (ptr_q == LAST);
    end

    a_r2_arm_next: assert property (@(posedge clk) disable iff (rst)
        start_in |=> (state_q == ST_LOADING && ptr_q == '0));

    a_r3_finish_parks: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOADING && ptr_q == LAST && !start_in && !strb_rise)
        |=> (state_q == ST_STANDBY));

    a_r7_strobe_clears: assert property (@(posedge clk) disable iff (rst)
        (strb_rise && !start_in) |=> (state_q == ST_STANDBY && ptr_q == '0));

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (sp_out && !start_in) |=> !sp_out);

    a_r3_ptr_range: assert property (@(posedge clk) disable iff (rst)
        ptr_q <= LAST);
endmodule

// File: rtl/col_pix_prep.sv
`timescale 1ns/1ps
module col_pix_prep #(
    parameter int PIX_PER_GRP = 6,
    parameter int PIX_W       = 6,
    localparam int GRP_W      = PIX_PER_GRP * PIX_W,
    localparam int HALF       = PIX_PER_GRP / 2
) (
    input  logic             inv_lo,
    input  logic             inv_hi,
    input  logic [GRP_W-1:0] grp_in,
    output logic [GRP_W-1:0] grp_out
);
    for (genvar p = 0; p < PIX_PER_GRP; p++) begin : g_pix
        if (p < HALF) begin : g_lo
            assign grp_out[p*PIX_W +: PIX_W] = grp_in[p*PIX_W +: PIX_W] ^ {PIX_W{inv_lo}};
        end else begin : g_hi
            assign grp_out[p*PIX_W +: PIX_W] = grp_in[p*PIX_W +: PIX_W] ^ {PIX_W{inv_hi}};
        end
    end
endmodule

// File: rtl/col_chan_bank.sv
`timescale 1ns/1ps
module col_chan_bank #(
    parameter int GROUPS      = 80,
    parameter int PIX_PER_GRP = 6,
    parameter int PIX_W       = 6,
    localparam int GRP_W      = PIX_PER_GRP * PIX_W,
    localparam int PTR_W      = (GROUPS > 1) ? $clog2(GROUPS) : 1,
    localparam int TOT_W      = GROUPS * GRP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dir_up,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_ptr,
    input  logic [GRP_W-1:0] grp_in,
    output logic [TOT_W-1:0] chan_out
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(GROUPS - 1);

    logic [PTR_W-1:0] slot;
    assign slot = dir_up ? wr_ptr : (LAST - wr_ptr);

    for (genvar s = 0; s < GROUPS; s++) begin : g_slot
        logic [GRP_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (wr_en && slot == PTR_W'(s)) begin
                q <= grp_in;
            end
        end
        assign chan_out[s*GRP_W +: GRP_W] = q;
    end

    a_r3_hold_without_write: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(chan_out));
endmodule

// File: rtl/col_loader.sv
`timescale 1ns/1ps
module col_loader #(
    parameter int CHANNELS    = 480,
    parameter int PIX_PER_GRP = 6,
    parameter int PIX_W       = 6,
    localparam int GRP_W      = PIX_PER_GRP * PIX_W,
    localparam int CH_W       = CHANNELS * PIX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dir_up,
    input  logic             line_strobe,
    input  logic             inv_lo,
    input  logic             inv_hi,
    input  logic [GRP_W-1:0] pix_in,
    inout  wire              sp_a,
    inout  wire              sp_b,
    output logic [CH_W-1:0]  chan_data
);
    localparam int GROUPS = CHANNELS / PIX_PER_GRP;
    localparam int PTR_W  = (GROUPS > 1) ? $clog2(GROUPS) : 1;

    logic             start_in;
    logic             sp_out;
    logic             wr_en;
    logic [PTR_W-1:0] wr_ptr;
    logic [GRP_W-1:0] grp_prep;

    // pin roles swap with direction
    assign sp_a     = dir_up ? 1'bz : sp_out;
    assign sp_b     = dir_up ? sp_out : 1'bz;
    assign start_in = dir_up ? sp_a : sp_b;

    col_fill_ctrl #(.GROUPS(GROUPS)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start_in (start_in),
        .strobe   (line_strobe),
        .wr_en    (wr_en),
        .wr_ptr   (wr_ptr),
        .sp_out   (sp_out)
    );

    col_pix_prep #(.PIX_PER_GRP(PIX_PER_GRP), .PIX_W(PIX_W)) u_prep (
        .inv_lo  (inv_lo),
        .inv_hi  (inv_hi),
        .grp_in  (pix_in),
        .grp_out (grp_prep)
    );

    col_chan_bank #(.GROUPS(GROUPS), .PIX_PER_GRP(PIX_PER_GRP), .PIX_W(PIX_W)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .dir_up   (dir_up),
        .wr_en    (wr_en),
        .wr_ptr   (wr_ptr),
        .grp_in   (grp_prep),
        .chan_out (chan_data)
    );
endmodule

// File: tb/sim_col_loader.sv
`timescale 1ns/1ps
module sim_col_loader;
    localparam int CH = 18;
    localparam int PP = 6;
    localparam int PW = 6;
    localparam int G  = CH / PP;
    localparam int GW = PP * PW;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst, dir_up, strobe, inv_lo, inv_hi;
    logic [GW-1:0] din;
    logic          a_en, a_val, b_en, b_val;
    wire           sp_a, sp_b;
    logic [CH*PW-1:0] chan;

    assign sp_a = a_en ? a_val : 1'bz;
    assign sp_b = b_en ? b_val : 1'bz;

    col_loader #(.CHANNELS(CH), .PIX_PER_GRP(PP), .PIX_W(PW)) u0 (
        .clk(clk), .rst(rst), .dir_up(dir_up), .line_strobe(strobe),
        .inv_lo(inv_lo), .inv_hi(inv_hi), .pix_in(din),
        .sp_a(sp_a), .sp_b(sp_b), .chan_data(chan)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [PW-1:0] m_ch [CH];
    logic          m_load;
    int            m_ptr;
    logic          m_strb;

    function automatic logic [GW-1:0] mk_word(input int base);
        logic [GW-1:0] w;
        for (int p = 0; p < PP; p++) w[p*PW +: PW] = PW'((base + p * 5) & 63);
        return w;
    endfunction

    task automatic compare(input string req);
        logic [CH*PW-1:0] e;
        logic             sp_exp, sp_act;
        for (int c = 0; c < CH; c++) e[c*PW +: PW] = m_ch[c];
        n_cmp++;
        if (chan !== e) begin
            n_bad++;
            $display("FAIL %s: chan_data act=%h exp=%h", req, chan, e);
        end
        sp_exp = m_load && (m_ptr == G - 1);
        sp_act = dir_up ? sp_b : sp_a;
        n_cmp++;
        if (sp_act !== sp_exp) begin
            n_bad++;
            $display("FAIL R9: start out act=%b exp=%b", sp_act, sp_exp);
        end
    endtask

    // called at a negedge; applies inputs, models the edge, checks at next negedge
    task automatic tick(input logic st, input logic sb, input logic [GW-1:0] w, input string req);
        logic rise;
        int   slot;
        din    = w;
        strobe = sb;
        if (dir_up) begin a_en = 1; a_val = st; b_en = 0; b_val = 0; end
        else        begin b_en = 1; b_val = st; a_en = 0; a_val = 0; end
        @(posedge clk);
        #1;
        if (rst) begin
            m_load = 0; m_ptr = 0; m_strb = 0;
            for (int c = 0; c < CH; c++) m_ch[c] = '0;
        end else begin
            rise   = sb & ~m_strb;
            m_strb = sb;
            if (st) begin
                m_load = 1; m_ptr = 0;
            end else if (rise) begin
                m_load = 0; m_ptr = 0;
            end else if (m_load) begin
                slot = dir_up ? m_ptr : (G - 1 - m_ptr);
                for (int p = 0; p < PP; p++)
                    m_ch[slot*PP + p] = w[p*PW +: PW] ^ {PW{(p < PP/2) ? inv_lo : inv_hi}};
                if (m_ptr == G - 1) begin m_load = 0; m_ptr = 0; end
                else m_ptr = m_ptr + 1;
            end
        end
        @(negedge clk);
        compare(req);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: act=running exp=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1; dir_up = 1; strobe = 0; inv_lo = 0; inv_hi = 0; din = '0;
        a_en = 1; a_val = 0; b_en = 0; b_val = 0;
        m_load = 0; m_ptr = 0; m_strb = 0;
        for (int c = 0; c < CH; c++) m_ch[c] = '0;
        @(negedge clk);
        tick(0, 0, '0, "R10");
        tick(0, 0, '0, "R10");
        rst = 0;
        tick(0, 0, mk_word(9), "R10 idle after reset");

        // R4 R5 R6 sweep with R2 arming and R3 standby
        for (int d = 0; d < 2; d++) begin
            for (int iv = 0; iv < 4; iv++) begin
                dir_up = d[0]; inv_lo = iv[0]; inv_hi = iv[1];
                tick(1, 0, mk_word(50), "R2 arming edge");
                for (int g = 0; g < G; g++)
                    tick(0, 0, mk_word(d*37 + iv*11 + g*6 + 1), d ? "R4 R6 fill" : "R5 R6 fill");
                tick(0, 0, mk_word(63), "R3 standby");
                tick(1'b0, 0, mk_word(17), "R3 standby");
            end
        end

        // R1 all 64 codes, plain data
        dir_up = 1; inv_lo = 0; inv_hi = 0;
        for (int k = 0; k < 4; k++) begin
            tick(1, 0, '0, "R2");
            for (int g = 0; g < G; g++) begin
                logic [GW-1:0] w;
                for (int p = 0; p < PP; p++) w[p*PW +: PW] = PW'((k*18 + g*6 + p) % 64);
                tick(0, 0, w, "R1 code sweep");
            end
        end

        // R7 strobe abort, held strobe, then R8 collision
        dir_up = 0;
        tick(1, 0, mk_word(3), "R2");
        tick(0, 0, mk_word(21), "R5");
        tick(0, 1, mk_word(40), "R7 strobe abort");
        tick(0, 1, mk_word(41), "R7 strobe held");
        tick(0, 0, mk_word(42), "R7 parked");
        tick(0, 1, mk_word(43), "R7 strobe in standby");
        tick(0, 0, mk_word(44), "R7");
        tick(1, 1, mk_word(45), "R8 start with strobe rise");
        for (int g = 0; g < G; g++) tick(0, 0, mk_word(30 + g), "R8 fill after collision");

        // R11 restart mid-line
        dir_up = 1; inv_hi = 1;
        tick(1, 0, mk_word(5), "R2");
        tick(0, 0, mk_word(12), "R4");
        tick(0, 0, mk_word(13), "R4");
        tick(1, 0, mk_word(14), "R11 restart edge");
        for (int g = 0; g < G; g++) tick(0, 0, mk_word(55 + g), "R11 refill");

        // R10 reset during filling
        tick(1, 0, mk_word(2), "R2");
        tick(0, 0, mk_word(7), "R4");
        rst = 1;
        tick(0, 0, mk_word(8), "R10 reset mid-line");
        rst = 0;
        tick(0, 0, mk_word(9), "R10 parked after reset");

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule